// File: doc/BRIEF.md
# Operand-Driven Node Firing Controller

This block is the control core of one processing element in a machine that has no program counter. Work arrives as messages, each carrying a value plus the node and input slot it is meant for. The controller stores each value in the slot of its target node. When the last missing input of a node arrives, the node's index joins a queue of ready nodes. The controller then takes ready nodes from that queue one at a time and evaluates each on a small integer arithmetic unit. For every outgoing edge of the fired node, it sends one message carrying the result.

Each node entry holds an opcode, a flag for one or two operands, two operand slots with presence bits, and a base and count into a separate edge store. Each edge entry names a destination node and its input slot. Both stores are loaded through configuration write ports before traffic starts. A cycle counter measures the runtime of a partition: it starts with the first accepted message and freezes once a programmed number of nodes have fired. A done flag rises at that moment.

The control sequence has three states. IDLE moves to FIRE when the ready queue is not empty, popping its head (transition "dispatch"). FIRE evaluates the node and clears its presence bits. It moves to EMIT when the node has at least one edge ("fan out"), or back to IDLE when it has none ("retire"). EMIT presents one message per edge and returns to IDLE when the last one is taken ("drain").

Top module: `dfpe_ctrl`

## Requirements
- R1: After reset, out_valid and done are 0, busy_cycles is 0, in_ready is 1 and no node holds an operand.
- R2: An accepted message (in_valid and in_ready high at a clock edge) stores in_data as operand A of node in_node when in_port is 0, and as operand B when in_port is 1; the value is held until the node fires.
- R3: A node configured for two operands becomes ready only once both A and B are present. A node configured for one operand becomes ready once A is present. A port-1 message sent to a one-operand node is ignored: it neither stores a value nor makes the node ready.
- R4: The result uses the 2-bit opcode: 0 gives A minus B modulo 2^DW; 1 gives the low DW bits of A times B; 2 gives the unsigned quotient A/B, or all ones when B is 0; 3 gives A. A one-operand node evaluates with B taken as 0.
- R5: A fired node with edge count N emits exactly N messages. They come from edge entries base, base+1, ... in that order, with the edge address wrapping modulo EDGES. Each message carries that entry's destination node and port and the node's result. A node with N = 0 emits nothing.
- R6: Nodes become ready in the order in which their last operand was accepted, and they fire in that same order.
- R7: Firing clears a node's presence bits, so the node fires again only after a fresh full set of operands.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_node, out_port and out_data hold steady. No message is dropped or repeated.
- R9: in_ready is 0 only in the state where a node is being evaluated. Messages are accepted while the output is stalled, and a message not accepted is kept by the sender without loss.
- R10: busy_cycles counts every clock edge from the edge that accepts the first message through the edge at which the fire_target-th node fires, and then stays constant.
- R11: done rises in the cycle after the fire_target-th node fires and stays high until reset. A fire_target of 0 never raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_node_we | input | 1 | Write a node entry (also clears its presence bits) |
| cfg_node_idx | input | NAW | Node entry to write |
| cfg_node_op | input | 2 | Opcode of the node |
| cfg_node_two | input | 1 | 1: node needs two operands, 0: one operand |
| cfg_node_ebase | input | EAW | First edge entry of the node |
| cfg_node_ecnt | input | EAW+1 | Number of edges of the node |
| cfg_edge_we | input | 1 | Write an edge entry |
| cfg_edge_idx | input | EAW | Edge entry to write |
| cfg_edge_dest | input | NAW | Destination node of the edge |
| cfg_edge_port | input | 1 | Destination input slot of the edge |
| fire_target | input | CW | Number of firings that ends the measurement (0: none) |
| in_valid | input | 1 | Input buffer holds a message |
| in_ready | output | 1 | Controller takes the message this cycle |
| in_node | input | NAW | Target node of the incoming operand |
| in_port | input | 1 | Target slot: 0 operand A, 1 operand B |
| in_data | input | DW | Operand value |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Output buffer has room |
| out_node | output | NAW | Destination node of the outgoing message |
| out_port | output | 1 | Destination slot of the outgoing message |
| out_data | output | DW | Result value |
| busy_cycles | output | CW | Measured processing cycles |
| done | output | 1 | Programmed firing count reached |

## Verification
On every cycle, the assertions check that a stalled outgoing message stays stable and that done, once high, stays high with a frozen counter. They also check that the counter never falls, that the ready queue never takes a push while full, and that a new outgoing message appears only after an evaluation. Other properties need the bench's scenarios. These include the arithmetic result of each opcode over swept operand values, the firing rule for one- and two-operand nodes, and the edge order with address wrap. The bench scenarios also cover firing in completion order while the output is blocked, re-firing after presence is cleared, and the exact cycle count against a model kept in the bench.

// File: rtl/dfpe_pkg.sv
package dfpe_pkg;
    typedef enum logic [1:0] {
        OP_SUB  = 2'd0,
        OP_MUL  = 2'd1,
        OP_DIV  = 2'd2,
        OP_PASS = 2'd3
    } dfpe_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_EMIT = 2'd2
    } dfpe_state_e;
endpackage

// File: rtl/dfpe_alu.sv
module dfpe_alu
    import dfpe_pkg::*;
#(
    parameter int DW = 16
) (
    input  dfpe_op_e        op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    logic [2*DW-1:0] prod;

    always_comb begin
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        unique case (op)
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DW-1:0];
            OP_DIV:  y = (b == '0) ? '1 : a / b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/dfpe_fifo.sv
module dfpe_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   cnt;

    assign head  = slots[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == FULL_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (push && !full) begin
                slots[wr_ptr] <= push_data;
                wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
            end
            if (pop && !empty)
                rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
            unique case ({push && !full, pop && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/dfpe_edge_mem.sv
module dfpe_edge_mem #(
    parameter int EDGES = 16,
    parameter int NAW   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(EDGES)-1:0] waddr,
    input  logic [NAW-1:0]           wdest,
    input  logic                     wport,
    input  logic [$clog2(EDGES)-1:0] raddr,
    output logic [NAW-1:0]           rdest,
    output logic                     rport
);
    logic [NAW-1:0] dest_m [EDGES];
    logic           port_m [EDGES];

    assign rdest = dest_m[raddr];
    assign rport = port_m[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < EDGES; i++) begin
                dest_m[i] <= '0;
                port_m[i] <= 1'b0;
            end
        end else if (we) begin
            dest_m[waddr] <= wdest;
            port_m[waddr] <= wport;
        end
    end
endmodule

// File: rtl/dfpe_ctrl.sv
module dfpe_ctrl
    import dfpe_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NODES = 8,
    parameter int EDGES = 16,
    parameter int CW    = 32,
    localparam int NAW  = $clog2(NODES),
    localparam int EAW  = $clog2(EDGES),
    localparam int ECW  = EAW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_node_we,
    input  logic [NAW-1:0] cfg_node_idx,
    input  logic [1:0]     cfg_node_op,
    input  logic           cfg_node_two,
    input  logic [EAW-1:0] cfg_node_ebase,
    input  logic [ECW-1:0] cfg_node_ecnt,
    input  logic           cfg_edge_we,
    input  logic [EAW-1:0] cfg_edge_idx,
    input  logic [NAW-1:0] cfg_edge_dest,
    input  logic           cfg_edge_port,
    input  logic [CW-1:0]  fire_target,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [NAW-1:0] in_node,
    input  logic           in_port,
    input  logic [DW-1:0]  in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [NAW-1:0] out_node,
    output logic           out_port,
    output logic [DW-1:0]  out_data,
    output logic [CW-1:0]  busy_cycles,
    output logic           done
);
    localparam logic [CW-1:0]  C_ONE = 1;
    localparam logic [EAW-1:0] E_ONE = 1;
    localparam logic [ECW-1:0] R_ONE = 1;

    // node store
    dfpe_op_e       node_op    [NODES];
    logic           node_two   [NODES];
    logic [EAW-1:0] node_ebase [NODES];
    logic [ECW-1:0] node_ecnt  [NODES];
    logic [DW-1:0]  opnd_a     [NODES];
    logic [DW-1:0]  opnd_b     [NODES];
    logic [NODES-1:0] pres_a, pres_b;

    dfpe_state_e    state, state_nx;
    logic [NAW-1:0] cur_idx;
    logic [DW-1:0]  result_q;
    logic [EAW-1:0] eptr;
    logic [ECW-1:0] erem;
    logic [CW-1:0]  fired_cnt;
    logic           counting;

    logic           accept, push, pop, q_empty, q_full;
    logic [NAW-1:0] q_head;
    logic           a_now, b_now, was_ready, now_ready;
    logic [DW-1:0]  alu_b, alu_y;
    logic [NAW-1:0] edge_dest;
    logic           edge_port;

    // arrival and firing-rule evaluation
    always_comb begin
        accept    = in_valid && in_ready;
        a_now     = pres_a[in_node] || !in_port;
        b_now     = pres_b[in_node] || (in_port && node_two[in_node]);
        was_ready = node_two[in_node] ? (pres_a[in_node] && pres_b[in_node])
                                      : pres_a[in_node];
        now_ready = node_two[in_node] ? (a_now && b_now) : a_now;
        push      = accept && now_ready && !was_ready;
        pop       = (state == ST_IDLE) && !q_empty;
    end

    dfpe_fifo #(.DEPTH(NODES), .W(NAW)) ready_q_i (
        .clk(clk), .rst(rst),
        .push(push), .push_data(in_node),
        .pop(pop), .head(q_head),
        .empty(q_empty), .full(q_full)
    );

    dfpe_edge_mem #(.EDGES(EDGES), .NAW(NAW)) edge_mem_i (
        .clk(clk), .rst(rst),
        .we(cfg_edge_we), .waddr(cfg_edge_idx),
        .wdest(cfg_edge_dest), .wport(cfg_edge_port),
        .raddr(eptr), .rdest(edge_dest), .rport(edge_port)
    );

    assign alu_b = node_two[cur_idx] ? opnd_b[cur_idx] : '0;

    dfpe_alu #(.DW(DW)) alu_i (
        .op(node_op[cur_idx]), .a(opnd_a[cur_idx]), .b(alu_b), .y(alu_y)
    );

    // node store updates
    always_ff @(posedge clk) begin
        if (rst) begin
            pres_a <= '0;
            pres_b <= '0;
            for (int i = 0; i < NODES; i++) begin
                node_op[i]    <= OP_SUB;
                node_two[i]   <= 1'b0;
                node_ebase[i] <= '0;
                node_ecnt[i]  <= '0;
                opnd_a[i]     <= '0;
                opnd_b[i]     <= '0;
            end
        end else begin
            if (cfg_node_we) begin
                node_op[cfg_node_idx]    <= dfpe_op_e'(cfg_node_op);
                node_two[cfg_node_idx]   <= cfg_node_two;
                node_ebase[cfg_node_idx] <= cfg_node_ebase;
                node_ecnt[cfg_node_idx]  <= cfg_node_ecnt;
                pres_a[cfg_node_idx]     <= 1'b0;
                pres_b[cfg_node_idx]     <= 1'b0;
            end
            if (accept) begin
                if (!in_port) begin
                    opnd_a[in_node] <= in_data;
                    pres_a[in_node] <= 1'b1;
                end else if (node_two[in_node]) begin
                    opnd_b[in_node] <= in_data;
                    pres_b[in_node] <= 1'b1;
                end
            end
            if (state == ST_FIRE) begin
                pres_a[cur_idx] <= 1'b0;
                pres_b[cur_idx] <= 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state: dispatch, fan out, retire, drain
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!q_empty) state_nx = ST_FIRE;
            ST_FIRE: state_nx = (node_ecnt[cur_idx] == '0) ? ST_IDLE : ST_EMIT;
            ST_EMIT: if (out_ready && erem == R_ONE) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        out_node  = edge_dest;
        out_port  = edge_port;
        out_data  = result_q;
        unique case (state)
            ST_IDLE: ;
            ST_FIRE: in_ready = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: in_ready = 1'b0;
        endcase
    end

    // firing datapath and measurement
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx     <= '0;
            result_q    <= '0;
            eptr        <= '0;
            erem        <= '0;
            fired_cnt   <= '0;
            counting    <= 1'b0;
            busy_cycles <= '0;
            done        <= 1'b0;
        end else begin
            if (pop) cur_idx <= q_head;
            if (state == ST_FIRE) begin
                result_q  <= alu_y;
                eptr      <= node_ebase[cur_idx];
                erem      <= node_ecnt[cur_idx];
                fired_cnt <= fired_cnt + C_ONE;
                if (fire_target != '0 && fired_cnt + C_ONE == fire_target)
                    done <= 1'b1;
            end
            if (state == ST_EMIT && out_ready) begin
                eptr <= eptr + E_ONE;
                erem <= erem - R_ONE;
            end
            if (accept) counting <= 1'b1;
            if (!done && (counting || accept)) busy_cycles <= busy_cycles + C_ONE;
        end
    end
endmodule

// File: rtl/dfpe_ctrl_chk.sv
module dfpe_ctrl_chk #(
    parameter int DW  = 16,
    parameter int NAW = 3,
    parameter int CW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           out_valid,
    input logic           out_ready,
    input logic [NAW-1:0] out_node,
    input logic           out_port,
    input logic [DW-1:0]  out_data,
    input logic [CW-1:0]  busy_cycles,
    input logic           done,
    input logic [1:0]     st,
    input logic           q_full,
    input logic           q_push,
    input logic           q_pop
);
    // R8: a blocked message stays unchanged
    a_r8_hold_msg: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_node) && $stable(out_port));

    // R11: done is sticky
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R10: counter frozen once done
    a_r10_busy_frozen: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(busy_cycles));

    // R10: counter never decreases
    a_r10_busy_monotonic: assert property (@(posedge clk) disable iff (rst)
        !done |=> busy_cycles >= $past(busy_cycles));

    // R11: done implies some cycles were measured
    a_r11_done_after_work: assert property (@(posedge clk) disable iff (rst)
        done |-> busy_cycles != '0);

    // R6: the ready queue never takes a push it cannot hold
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        q_full |-> !(q_push && !q_pop));

    // R5: a fresh outgoing message follows an evaluation
    a_r5_emit_after_fire: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(st) == 2'd1);
endmodule

bind dfpe_ctrl dfpe_ctrl_chk #(.DW(DW), .NAW(NAW), .CW(CW)) chk_i (
    .clk(clk), .rst(rst),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_node(out_node), .out_port(out_port), .out_data(out_data),
    .busy_cycles(busy_cycles), .done(done),
    .st(state), .q_full(q_full), .q_push(push), .q_pop(pop)
);

// File: tb/dfpe_ctrl_tb_top.sv
`timescale 1ns/1ps
module dfpe_ctrl_tb_top;
    localparam int DW = 16, NAW = 3, EAW = 4, CW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_node_we = 0, cfg_node_two = 0, cfg_edge_we = 0, cfg_edge_port = 0;
    logic [NAW-1:0] cfg_node_idx = '0, cfg_edge_dest = '0;
    logic [1:0]     cfg_node_op = '0;
    logic [EAW-1:0] cfg_node_ebase = '0, cfg_edge_idx = '0;
    logic [EAW:0]   cfg_node_ecnt = '0;
    logic [CW-1:0]  fire_target = '0;
    logic in_valid = 0, in_port = 0, out_ready = 1;
    logic [NAW-1:0] in_node = '0;
    logic [DW-1:0]  in_data = '0;
    logic in_ready, out_valid, out_port, done;
    logic [NAW-1:0] out_node;
    logic [DW-1:0]  out_data;
    logic [CW-1:0]  busy_cycles;

    int checks = 0, errors = 0;
    logic [NAW+DW:0] mq[$];
    int  acc_cnt = 0;
    logic s_acc = 0, s_done = 0, b_started = 0;
    logic [CW-1:0] b_cnt = '0;

    always #5 clk = ~clk;

    dfpe_ctrl dut_i (.*);

    // sample away from the active edge
    always @(negedge clk) begin
        s_acc  = in_valid && in_ready;
        s_done = done;
        if (!rst && out_valid && out_ready) mq.push_back({out_node, out_port, out_data});
        if (!rst && s_acc) acc_cnt++;
    end

    // bench model of the measured cycles
    always @(posedge clk) begin
        if (rst) begin
            b_cnt <= '0; b_started <= 1'b0;
        end else begin
            if (!s_done && (b_started || s_acc)) b_cnt <= b_cnt + 1;
            if (s_acc) b_started <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(3); rst = 1'b0;
    endtask

    task automatic set_node(input int idx, input int op, input bit two, input int base, input int cnt);
        cfg_node_we = 1; cfg_node_idx = NAW'(idx); cfg_node_op = 2'(op);
        cfg_node_two = two; cfg_node_ebase = EAW'(base); cfg_node_ecnt = (EAW+1)'(cnt);
        tick(1); cfg_node_we = 0;
    endtask

    task automatic set_edge(input int idx, input int dest, input bit port);
        cfg_edge_we = 1; cfg_edge_idx = EAW'(idx); cfg_edge_dest = NAW'(dest); cfg_edge_port = port;
        tick(1); cfg_edge_we = 0;
    endtask

    task automatic send(input int n, input bit p, input logic [DW-1:0] d);
        bit rdy;
        in_valid = 1; in_node = NAW'(n); in_port = p; in_data = d;
        forever begin
            @(negedge clk); rdy = in_ready;
            @(posedge clk); #1;
            if (rdy) break;
        end
        in_valid = 0;
    endtask

    task automatic expect_msg(input int n, input bit p, input logic [DW-1:0] d, input string tag);
        logic [NAW+DW:0] got, exp;
        int w = 0;
        exp = {NAW'(n), p, d};
        while (mq.size() == 0 && w < 60) begin tick(1); w++; end
        if (mq.size() == 0) chk(0, {tag, " no message"}, 0, exp);
        else begin
            got = mq.pop_front();
            chk(got == exp, tag, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_alu(input int op, input logic [DW-1:0] a,
                                              input logic [DW-1:0] b, input bit two);
        logic [DW-1:0] bb = two ? b : '0;
        logic [2*DW-1:0] pr = 32'(a) * 32'(bb);
        case (op)
            0: return a - bb;
            1: return pr[DW-1:0];
            2: return (bb == 0) ? 16'hFFFF : a / bb;
            default: return a;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a0;
        logic [CW-1:0] frozen;
        do_reset();
        // R1
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(busy_cycles == 0, "R1 busy_cycles", busy_cycles, 0);
        chk(in_ready == 1, "R1 in_ready", in_ready, 1);

        // R2 R4 R7: sweep opcodes, operand counts and operand values on node 0
        set_edge(0, 5, 0);
        for (int op = 0; op < 4; op++)
            for (int two = 0; two < 2; two++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++) begin
                        logic [DW-1:0] a, b;
                        a = (i == 7) ? 16'hFFFF : 16'((i * 9973) & 16'hFFFF);
                        b = (j == 7) ? 16'hFFFF : 16'(j * 313);
                        set_node(0, op, two[0], 0, 1);
                        if (two == 1 && ((i + j) % 2 == 1)) begin
                            send(0, 1, b); send(0, 0, a);
                        end else begin
                            send(0, 0, a);
                            if (two == 1) send(0, 1, b);
                        end
                        expect_msg(5, 0, ref_alu(op, a, b, two[0]), "R4 R2 alu sweep");
                    end
        chk(mq.size() == 0, "R7 no repeated firing", mq.size(), 0);
        chk(done == 0, "R11 target zero keeps done low", done, 0);

        // R3: two-operand node waits for B
        set_node(0, 0, 1, 0, 1);
        send(0, 0, 16'd50); tick(6);
        chk(mq.size() == 0 && out_valid == 0, "R3 two-operand waits", mq.size(), 0);
        send(0, 1, 16'd8);
        expect_msg(5, 0, 16'd42, "R3 two-operand fires");

        // R3: port 1 to a one-operand node is ignored
        set_node(2, 0, 0, 8, 1);
        set_edge(8, 6, 1);
        send(2, 1, 16'h1234); tick(6);
        chk(mq.size() == 0 && out_valid == 0, "R3 port1 ignored", mq.size(), 0);
        send(2, 0, 16'h00AB);
        expect_msg(6, 1, 16'h00AB, "R3 single fires on A");

        // R5 R8: fan-out with edge wrap under output stall
        set_edge(14, 2, 0); set_edge(15, 3, 1); set_edge(0, 7, 0);
        set_node(1, 1, 1, 14, 3);
        out_ready = 0;
        send(1, 0, 16'd12); send(1, 1, 16'd11);
        tick(6);
        chk(out_valid == 1, "R8 valid held", out_valid, 1);
        chk(out_node == 2 && out_port == 0 && out_data == 16'd132, "R8 message held",
            {out_node, out_port, out_data}, {3'd2, 1'b0, 16'd132});
        chk(mq.size() == 0, "R8 nothing taken", mq.size(), 0);
        out_ready = 1;
        expect_msg(2, 0, 16'd132, "R5 edge 14");
        expect_msg(3, 1, 16'd132, "R5 edge 15");
        expect_msg(7, 0, 16'd132, "R5 edge 0 after wrap");

        // R6 R9: completion order while output blocked
        set_edge(1, 4, 0); set_edge(2, 4, 1); set_edge(3, 5, 1); set_edge(4, 6, 0);
        set_node(3, 3, 0, 1, 2);
        set_node(4, 3, 0, 3, 1);
        set_node(5, 3, 0, 4, 1);
        out_ready = 0;
        send(3, 0, 16'h11); tick(3);
        a0 = acc_cnt;
        send(4, 0, 16'h22); send(5, 0, 16'h33);
        chk(acc_cnt == a0 + 2, "R9 accepted during stall", acc_cnt, a0 + 2);
        out_ready = 1;
        expect_msg(4, 0, 16'h11, "R6 first node edge a");
        expect_msg(4, 1, 16'h11, "R6 first node edge b");
        expect_msg(5, 1, 16'h22, "R6 second node");
        expect_msg(6, 0, 16'h33, "R6 third node");
        // R7: node fires again with a new operand
        send(3, 0, 16'h44);
        expect_msg(4, 0, 16'h44, "R7 refire a");
        expect_msg(4, 1, 16'h44, "R7 refire b");
        tick(5);
        chk(mq.size() == 0, "R5 no extra messages", mq.size(), 0);

        // R10 R11: measurement
        do_reset();
        chk(busy_cycles == 0 && done == 0, "R1 after second reset", busy_cycles, 0);
        fire_target = 3;
        set_node(0, 3, 0, 0, 0);
        set_node(1, 3, 0, 0, 1);
        set_edge(0, 3, 0);
        tick(4);
        chk(busy_cycles == 0, "R10 idle before first message", busy_cycles, 0);
        send(0, 0, 16'd5); tick(5);
        chk(mq.size() == 0, "R5 zero-edge node silent", mq.size(), 0);
        send(1, 0, 16'd7);
        expect_msg(3, 0, 16'd7, "R5 single edge");
        tick(10);
        chk(done == 0, "R11 done low before target", done, 0);
        send(0, 0, 16'd9); tick(5);
        chk(done == 1, "R11 done at target", done, 1);
        chk(busy_cycles == b_cnt, "R10 measured cycles", busy_cycles, b_cnt);
        frozen = busy_cycles;
        tick(10);
        chk(busy_cycles == frozen, "R10 counter frozen", busy_cycles, frozen);
        chk(done == 1, "R11 done sticky", done, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule